// File: doc/BRIEF.md
# Buried Register Logic Cell Array

This block is a bank of internal logic cells that have no pin of their own. Each cell ORs five product terms into one sum and keeps a single state bit. The state bit behaves as a D or a T flip-flop, chosen by configuration. The cell's feedback line goes back onto a shared routing bus, and a configuration bit chooses what that line carries: the stored bit, or the sum that feeds the register.

Each cell has its own set, clear and clock product terms. The cell's clock is either its clock term alone, or that term ANDed with a regional clock shared by the whole bank. The block runs on one system clock. A rising edge of the selected cell clock is found by sampling it on the system clock, and that detected edge acts as the register's clock enable. Set and clear act on every system clock edge, whatever the cell clock does, and clear wins over set. The bank holds `NUM_CELLS` copies of the cell, six by default.

Top module: `blc_bank`

## Requirements
- R1: Product term k of cell c is bit c*5+k of `pterm_i`. When `cfg_fbq_i[c]` is 0, `fb_o[c]` equals the OR of that cell's five terms in the same cycle, with no clock edge involved.
- R2: When `cfg_fbq_i[c]` is 1, `fb_o[c]` shows the cell's register.
- R3: With `cfg_toggle_i[c]`=0 (D mode), the register takes the cell's sum on a system clock edge at which a rising edge of the cell clock is detected.
- R4: With `cfg_toggle_i[c]`=1 (T mode), on a detected cell clock edge the register inverts when the sum is 1 and holds when the sum is 0.
- R5: With `cfg_sync_i[c]`=0 the cell clock is `clkterm_i[c]` alone. A 0-to-1 change between two system clock samples counts as one edge.
- R6: With `cfg_sync_i[c]`=1 the cell clock is `rclk_i` AND `clkterm_i[c]`. A clock term pulse while `rclk_i` is low produces no edge. A rise of `rclk_i` while the term is held high does produce one.
- R7: `clear_i[c]`=1 forces the register to 0 at the next system clock edge. This holds even with `preset_i[c]` high or a cell clock edge in that cycle.
- R8: `preset_i[c]`=1 with clear low forces the register to 1 at the next system clock edge, with no cell clock edge needed.
- R9: With no set, no clear and no detected cell clock edge, the register holds. Changes of the sum are ignored, and so is a clock term that stays high.
- R10: Each cell uses only its own terms and configuration. Stimulus on one cell leaves every other cell's feedback unchanged.
- R11: While `rst_n` is low every register is 0. Reset is released through a two-stage synchronizer on the system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rclk_i | input | 1 | Regional clock shared by all cells |
| pterm_i | input | NUM_CELLS*NUM_PT | Sum product terms, five per cell |
| preset_i | input | NUM_CELLS | Per-cell set term |
| clear_i | input | NUM_CELLS | Per-cell clear term |
| clkterm_i | input | NUM_CELLS | Per-cell clock term |
| cfg_toggle_i | input | NUM_CELLS | 1 = T-type, 0 = D-type |
| cfg_fbq_i | input | NUM_CELLS | 1 = feed back register, 0 = feed back sum |
| cfg_sync_i | input | NUM_CELLS | 1 = clock term ANDed with regional clock |
| fb_o | output | NUM_CELLS | Feedback lines to the regional bus |

## Verification
The hardest case is the ANDed clock in regional mode. An edge can come from the clock term rising while the regional clock is high, or from the regional clock rising while the term is already held high. A term pulse under a low regional clock must produce no edge at all. The stimulus sets up each of these orders in turn on one cell. Because the regional clock is shared, the other cells, which run in term-only mode, are checked against the model after every scenario to confirm that those regional clock changes did not move them.

// File: rtl/blc_pkg.sv
package blc_pkg;

  typedef struct packed {
    logic toggle;  // 1: T-type, 0: D-type
    logic fb_q;    // 1: feedback from register, 0: from sum
    logic sync;    // 1: clock term ANDed with regional clock
  } cell_cfg_t;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_CLEAR  = 2'd1,
    ACT_PRESET = 2'd2,
    ACT_LOAD   = 2'd3
  } cell_act_e;

endpackage

// File: rtl/blc_rst_sync.sv
module blc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/blc_sum_term.sv
module blc_sum_term #(
  parameter int NUM_PT = 5
) (
  input  logic [NUM_PT-1:0] pterm_i,
  output logic              sum_o
);

  logic [NUM_PT-1:0] chain;

  assign chain[0] = pterm_i[0];

  for (genvar k = 1; k < NUM_PT; k++) begin : g_or
    assign chain[k] = chain[k-1] | pterm_i[k];
  end

  assign sum_o = chain[NUM_PT-1];

endmodule

// File: rtl/blc_clk_sel.sv
module blc_clk_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic rclk_i,
  input  logic clkterm_i,
  input  logic sync_i,
  output logic edge_o
);

  logic lvl;
  logic lvl_q;
  logic lvl_d;

  always_comb begin
    if (sync_i) begin
      lvl = rclk_i & clkterm_i;
    end else begin
      lvl = clkterm_i;
    end
    lvl_d = lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
    end
  end

  assign edge_o = lvl & ~lvl_q;

  AST_SYNC_LOW_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_i && !rclk_i) |-> !edge_o);  // R6

endmodule

// File: rtl/blc_cell.sv
module blc_cell
  import blc_pkg::*;
#(
  parameter int NUM_PT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rclk_i,
  input  logic [NUM_PT-1:0] pterm_i,
  input  logic              preset_i,
  input  logic              clear_i,
  input  logic              clkterm_i,
  input  cell_cfg_t         cfg_i,
  output logic              fb_o
);

  logic      sum;
  logic      clk_edge;
  logic      q_r;
  logic      q_d;
  logic      q_en;
  cell_act_e act;

  blc_sum_term #(.NUM_PT(NUM_PT)) u_sum (
    .pterm_i (pterm_i),
    .sum_o   (sum)
  );

  blc_clk_sel u_clk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rclk_i    (rclk_i),
    .clkterm_i (clkterm_i),
    .sync_i    (cfg_i.sync),
    .edge_o    (clk_edge)
  );

  // Priority: clear, then preset, then a detected cell clock edge
  always_comb begin
    if (clear_i) begin
      act = ACT_CLEAR;
    end else if (preset_i) begin
      act = ACT_PRESET;
    end else if (clk_edge) begin
      act = ACT_LOAD;
    end else begin
      act = ACT_HOLD;
    end
  end

  always_comb begin
    q_en = 1'b1;
    q_d  = q_r;
    unique case (act)
      ACT_CLEAR:  q_d = 1'b0;
      ACT_PRESET: q_d = 1'b1;
      ACT_LOAD:   q_d = cfg_i.toggle ? (q_r ^ sum) : sum;
      default:    q_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= 1'b0;
    end else if (q_en) begin
      q_r <= q_d;
    end
  end

  assign fb_o = cfg_i.fb_q ? q_r : sum;

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !q_r);  // R7
  AST_PRESET_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (preset_i && !clear_i) |=> q_r);  // R8
  AST_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && !preset_i && !clk_edge) |=> $stable(q_r));  // R9
  AST_D_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && !preset_i && clk_edge && !cfg_i.toggle) |=> (q_r == $past(sum)));  // R3
  AST_T_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && !preset_i && clk_edge && cfg_i.toggle) |=> (q_r == ($past(q_r) ^ $past(sum))));  // R4

endmodule

// File: rtl/blc_bank.sv
module blc_bank
  import blc_pkg::*;
#(
  parameter int NUM_CELLS = 6,
  parameter int NUM_PT    = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rclk_i,
  input  logic [NUM_CELLS*NUM_PT-1:0] pterm_i,
  input  logic [NUM_CELLS-1:0]        preset_i,
  input  logic [NUM_CELLS-1:0]        clear_i,
  input  logic [NUM_CELLS-1:0]        clkterm_i,
  input  logic [NUM_CELLS-1:0]        cfg_toggle_i,
  input  logic [NUM_CELLS-1:0]        cfg_fbq_i,
  input  logic [NUM_CELLS-1:0]        cfg_sync_i,
  output logic [NUM_CELLS-1:0]        fb_o
);

  localparam int RST_STAGES = 2;

  logic rst_int_n;

  blc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
    cell_cfg_t cfg;

    assign cfg.toggle = cfg_toggle_i[c];
    assign cfg.fb_q   = cfg_fbq_i[c];
    assign cfg.sync   = cfg_sync_i[c];

    blc_cell #(.NUM_PT(NUM_PT)) u_cell (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .rclk_i    (rclk_i),
      .pterm_i   (pterm_i[c*NUM_PT +: NUM_PT]),
      .preset_i  (preset_i[c]),
      .clear_i   (clear_i[c]),
      .clkterm_i (clkterm_i[c]),
      .cfg_i     (cfg),
      .fb_o      (fb_o[c])
    );
  end

  AST_RESET_FB_LOW: assert property (@(posedge clk)
    (!rst_int_n) |-> ((fb_o & cfg_fbq_i) == '0));  // R11

endmodule

// File: tb/blc_bank_tb.sv
module blc_bank_tb;

  localparam int NC = 6;
  localparam int NP = 5;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              rclk_i;
  logic [NC*NP-1:0]  pterm_i;
  logic [NC-1:0]     preset_i, clear_i, clkterm_i;
  logic [NC-1:0]     cfg_toggle_i, cfg_fbq_i, cfg_sync_i;
  logic [NC-1:0]     fb_o;

  logic [NC-1:0]     exp_q;
  int                n_chk = 0;
  int                n_err = 0;
  bit                done  = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  blc_bank #(.NUM_CELLS(NC), .NUM_PT(NP)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .rclk_i       (rclk_i),
    .pterm_i      (pterm_i),
    .preset_i     (preset_i),
    .clear_i      (clear_i),
    .clkterm_i    (clkterm_i),
    .cfg_toggle_i (cfg_toggle_i),
    .cfg_fbq_i    (cfg_fbq_i),
    .cfg_sync_i   (cfg_sync_i),
    .fb_o         (fb_o)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Compare every cell with the model (R10)
  task automatic check_all(string req);
    for (int c = 0; c < NC; c++) begin
      logic e;
      e = cfg_fbq_i[c] ? exp_q[c] : (|pterm_i[c*NP +: NP]);
      chk(req, fb_o[c], e);
    end
  endtask

  task automatic clk_pulse(int c);
    clkterm_i[c] = 1'b0; tick();
    clkterm_i[c] = 1'b1; tick();
    clkterm_i[c] = 1'b0; tick();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) tick();
    check_all("R11 reset");
    rst_n = 1'b1;
    repeat (3) tick();
    check_all("R11 after release");
  endtask

  task automatic t_comb_fb();
    pterm_i[0*NP +: NP] = 5'b00000; #1;
    chk("R1 zero", fb_o[0], 1'b0);
    for (int k = 0; k < NP; k++) begin
      pterm_i[0*NP +: NP] = 5'b00001 << k; #1;
      chk("R1 single term", fb_o[0], 1'b1);
    end
    pterm_i[0*NP +: NP] = 5'b10110; #1;
    chk("R1 multi", fb_o[0], 1'b1);
    pterm_i[0*NP +: NP] = 5'b00000; #1;
    chk("R1 back to zero", fb_o[0], 1'b0);
    tick();
    check_all("R10 after R1");
  endtask

  task automatic t_dload();
    pterm_i[1*NP +: NP] = 5'b01000;
    clk_pulse(1); exp_q[1] = 1'b1;
    chk("R3 R5 D load one", fb_o[1], 1'b1);
    pterm_i[1*NP +: NP] = 5'b00000;
    clk_pulse(1); exp_q[1] = 1'b0;
    chk("R3 D load zero", fb_o[1], 1'b0);
    check_all("R2 R10 after D");
  endtask

  task automatic t_hold();
    pterm_i[1*NP +: NP] = 5'b11111;
    repeat (3) tick();
    chk("R9 sum change ignored", fb_o[1], 1'b0);
    clkterm_i[1] = 1'b1; tick();  // edge: loads 1
    exp_q[1] = 1'b1;
    chk("R5 edge loads", fb_o[1], 1'b1);
    pterm_i[1*NP +: NP] = 5'b00000;
    repeat (3) tick();            // term held high: no new edge
    chk("R9 held term ignored", fb_o[1], 1'b1);
    clkterm_i[1] = 1'b0; tick();
    chk("R9 falling term ignored", fb_o[1], 1'b1);
    check_all("R10 after hold");
  endtask

  task automatic t_toggle();
    pterm_i[2*NP +: NP] = 5'b00010;
    clk_pulse(2); exp_q[2] = 1'b1;
    chk("R4 toggle up", fb_o[2], 1'b1);
    clk_pulse(2); exp_q[2] = 1'b0;
    chk("R4 toggle down", fb_o[2], 1'b0);
    clk_pulse(2); exp_q[2] = 1'b1;
    pterm_i[2*NP +: NP] = 5'b00000;
    clk_pulse(2);
    chk("R4 sum zero holds", fb_o[2], 1'b1);
    check_all("R10 after toggle");
  endtask

  task automatic t_sync();
    pterm_i[3*NP +: NP] = 5'b10000;
    rclk_i = 1'b0;
    clk_pulse(3);
    chk("R6 term under low rclk", fb_o[3], 1'b0);
    rclk_i = 1'b1; tick();
    clk_pulse(3); exp_q[3] = 1'b1;
    chk("R6 term under high rclk", fb_o[3], 1'b1);
    pterm_i[3*NP +: NP] = 5'b00000;
    rclk_i = 1'b0; clkterm_i[3] = 1'b1; tick();
    chk("R6 term high rclk low", fb_o[3], 1'b1);
    rclk_i = 1'b1; tick(); exp_q[3] = 1'b0;
    chk("R6 rclk rise loads", fb_o[3], 1'b0);
    clkterm_i[3] = 1'b0; rclk_i = 1'b0; tick();
    check_all("R10 after rclk activity");
  endtask

  task automatic t_clr_pre();
    preset_i[4] = 1'b1; tick(); exp_q[4] = 1'b1;
    chk("R8 preset", fb_o[4], 1'b1);
    preset_i[4] = 1'b0; tick();
    chk("R9 hold after preset", fb_o[4], 1'b1);
    clear_i[4] = 1'b1; preset_i[4] = 1'b1; tick(); exp_q[4] = 1'b0;
    chk("R7 clear over preset", fb_o[4], 1'b0);
    clear_i[4] = 1'b0; tick(); exp_q[4] = 1'b1;
    chk("R8 preset alone again", fb_o[4], 1'b1);
    preset_i[4] = 1'b0;
    pterm_i[4*NP +: NP] = 5'b00100;
    clkterm_i[4] = 1'b0; tick();
    clkterm_i[4] = 1'b1; clear_i[4] = 1'b1; tick(); exp_q[4] = 1'b0;
    chk("R7 clear over clock edge", fb_o[4], 1'b0);
    clear_i[4] = 1'b0; clkterm_i[4] = 1'b0; tick();
    chk("R9 no edge after clear", fb_o[4], 1'b0);
    pterm_i[4*NP +: NP] = 5'b00000;
    #1;
    check_all("R10 after clear preset");
  endtask

  initial begin
    rst_n        = 1'b0;
    rclk_i       = 1'b0;
    pterm_i      = '0;
    preset_i     = '0;
    clear_i      = '0;
    clkterm_i    = '0;
    cfg_toggle_i = 6'b000100;
    cfg_sync_i   = 6'b001000;
    cfg_fbq_i    = 6'b111110;
    exp_q        = '0;
    t_reset();
    t_comb_fb();
    t_dload();
    t_hold();
    t_toggle();
    t_sync();
    t_clr_pre();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule